// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt requests from five sources and presents at most one of them to a processor core. Two sources are external pins, which are active low. The other three are request levels from on-chip peripherals: a serial port, timer 0 and timer 1. Each external pin has its own trigger mode. In level mode the request follows the synchronized pin for as long as the pin stays low. In edge mode a falling edge is latched into a pending flag that is held until the processor acknowledges that source.

A global enable and a per-source enable mask the requests. A per-source priority bit then places each source in the high group or the low group. Within a group a fixed polling order picks the winner. The block outputs the winner's index and its vector address. It tracks which priority levels are currently being serviced: a high-priority request can interrupt a low-priority handler, while other requests wait for the return signal. Configuration is written through three strobed registers.

Top module: `intc_top`

## Requirements
- R1: After reset, the enables and priorities are all zero, both external pins are in level mode, and `irq` is low whatever the inputs are.
- R2: While the global enable (enable register bit 5) is clear, `irq` stays low even when enabled sources request.
- R3: A source whose enable bit (enable register bit = source index) is clear never wins, even when it is the only requester.
- R4: In level mode (mode bit 0 for ext0, mode bit 1 for ext1, value 0), a low external pin raises a request two clock edges after it is driven. The request lasts while the pin stays low, so a pin still low at return raises the request again.
- R5: In edge mode (mode bit value 1), a falling edge on the pin raises a request three clock edges later. The request holds after the pin goes high again, and it is removed by an acknowledge of that source.
- R6: Within one priority group the winner is the lowest index in the order ext0=0, timer0=1, ext1=2, timer1=3, serial=4. This index is reported on `irq_src`.
- R7: Any requesting source with its priority bit (bit = source index) set to 1 wins over every source whose priority bit is 0.
- R8: `irq_vec` equals 0x0003 + 8 × `irq_src` (0x0003, 0x000B, 0x0013, 0x001B, 0x0023).
- R9: While a low-priority service is in progress, a high-priority request raises `irq`.
- R10: While a service is in progress, a request of the same or lower priority keeps `irq` low.
- R11: `reti` ends the innermost service in progress (high before low). Once no service blocks a pending request, that request is presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_n | input | 2 | External request pins, active low; bit 0 is ext0 |
| tmr0_req | input | 1 | Timer 0 request level |
| tmr1_req | input | 1 | Timer 1 request level |
| ser_req | input | 1 | Serial port request level |
| mode_we | input | 1 | Write strobe for the trigger mode register |
| mode_wdata | input | 2 | Trigger modes, 1 = edge, 0 = level |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 6 | Bit 5 global enable, bits 4:0 per source |
| pri_we | input | 1 | Write strobe for the priority register |
| pri_wdata | input | 5 | Priority bit per source, 1 = high |
| ack | input | 1 | Processor accepts the presented request |
| reti | input | 1 | Processor returns from the current handler |
| irq | output | 1 | A request is presented |
| irq_src | output | 3 | Index of the presented source |
| irq_vec | output | 16 | Vector address of the presented source |

## Verification
Requests from the internal peripherals reach `irq` in the same cycle. A register write, `ack` or `reti` shows on the outputs after one clock edge. An external pin in level mode takes two edges, and in edge mode three. The bench drives every input just after a falling clock edge and counts whole rising edges before it samples at the next falling edge. An external pin is checked one edge before its due cycle as well as on it, which catches a request that arrives too early. Checks that state is held, such as a latched edge after the pin is released or a request waiting during a service, are made several edges after the stimulus.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NUM_SRC  = 5;
    localparam int NUM_EXT  = 2;
    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int VEC_W    = 16;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'h0003;
    localparam int VEC_STEP_SH = 3;

    typedef enum logic [IDX_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4
    } src_e;

    typedef struct packed {
        logic             valid;
        logic             high;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        return VEC_BASE + (VEC_W'(idx) << VEC_STEP_SH);
    endfunction
endpackage

// File: rtl/intc_ext_in.sv
module intc_ext_in (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req
);
    logic s1, s2, s3;
    logic pend;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= pin_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign fall = s3 & ~s2;

    always_ff @(posedge clk) begin
        if (rst || !edge_mode) begin
            pend <= 1'b0;
        end else begin
            pend <= (pend & ~clr) | fall;
        end
    end

    assign req = edge_mode ? pend : ~s2;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] pri,
    output pick_t        pick
);
    localparam int IW = $clog2(N);

    logic [N-1:0] hi_req;
    logic [N-1:0] sel_req;

    assign hi_req  = req & pri;
    assign sel_req = (|hi_req) ? hi_req : req;

    always_comb begin
        pick       = '0;
        pick.valid = |req;
        pick.high  = |hi_req;
        for (int i = N - 1; i >= 0; i--) begin
            if (sel_req[i]) pick.idx = IW'(i);
        end
    end
endmodule

// File: rtl/intc_svc.sv
module intc_svc (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic take_high,
    input  logic reti,
    output logic svc_lo,
    output logic svc_hi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            svc_lo <= 1'b0;
            svc_hi <= 1'b0;
        end else begin
            if (reti) begin
                if (svc_hi) svc_hi <= 1'b0;
                else        svc_lo <= 1'b0;
            end
            if (take) begin
                if (take_high) svc_hi <= 1'b1;
                else           svc_lo <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_EXT-1:0]   ext_n,
    input  logic                 tmr0_req,
    input  logic                 tmr1_req,
    input  logic                 ser_req,
    input  logic                 mode_we,
    input  logic [NUM_EXT-1:0]   mode_wdata,
    input  logic                 en_we,
    input  logic [NUM_SRC:0]     en_wdata,
    input  logic                 pri_we,
    input  logic [NUM_SRC-1:0]   pri_wdata,
    input  logic                 ack,
    input  logic                 reti,
    output logic                 irq,
    output logic [IDX_W-1:0]     irq_src,
    output logic [VEC_W-1:0]     irq_vec
);
    logic [NUM_EXT-1:0] mode_q;
    logic               en_glb_q;
    logic [NUM_SRC-1:0] en_src_q;
    logic [NUM_SRC-1:0] pri_q;
    logic [NUM_EXT-1:0] ext_req;
    logic [NUM_EXT-1:0] ext_clr;
    logic [NUM_SRC-1:0] raw_req;
    pick_t              pick;
    logic               svc_lo, svc_hi;
    logic               allow;
    logic               take;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            en_glb_q <= 1'b0;
            en_src_q <= '0;
            pri_q    <= '0;
        end else begin
            if (mode_we) mode_q <= mode_wdata;
            if (en_we) begin
                en_glb_q <= en_wdata[NUM_SRC];
                en_src_q <= en_wdata[NUM_SRC-1:0];
            end
            if (pri_we) pri_q <= pri_wdata;
        end
    end

    localparam logic [IDX_W-1:0] EXT_IDX [NUM_EXT] = '{SRC_EXT0, SRC_EXT1};

    for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
        assign ext_clr[g] = take && (irq_src == EXT_IDX[g]);
        intc_ext_in u_ext (
            .clk       (clk),
            .rst       (rst),
            .pin_n     (ext_n[g]),
            .edge_mode (mode_q[g]),
            .clr       (ext_clr[g]),
            .req       (ext_req[g])
        );
    end

    always_comb begin
        raw_req           = '0;
        raw_req[SRC_EXT0] = ext_req[0];
        raw_req[SRC_TMR0] = tmr0_req;
        raw_req[SRC_EXT1] = ext_req[1];
        raw_req[SRC_TMR1] = tmr1_req;
        raw_req[SRC_SER]  = ser_req;
    end

    intc_arbiter #(.N(NUM_SRC)) u_arb (
        .req  (raw_req & en_src_q & {NUM_SRC{en_glb_q}}),
        .pri  (pri_q),
        .pick (pick)
    );

    assign allow = pick.high ? !svc_hi : !(svc_hi || svc_lo);
    assign irq     = pick.valid && allow;
    assign irq_src = pick.idx;
    assign irq_vec = vec_of(pick.idx);
    assign take    = ack && irq;

    intc_svc u_svc (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .take_high (pick.high),
        .reti      (reti),
        .svc_lo    (svc_lo),
        .svc_hi    (svc_hi)
    );
endmodule

// File: rtl/intc_chk.sv
module intc_chk
    import intc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               irq,
    input logic [IDX_W-1:0]   irq_src,
    input logic [VEC_W-1:0]   irq_vec,
    input logic               en_glb,
    input logic [NUM_SRC-1:0] en_src,
    input logic [NUM_SRC-1:0] pri,
    input logic               svc_lo,
    input logic               svc_hi
);
    a_r2_global_gate: assert property (@(posedge clk) disable iff (rst)
        !en_glb |-> !irq);

    a_r3_enabled_only: assert property (@(posedge clk) disable iff (rst)
        irq |-> en_src[irq_src]);

    a_r8_vec_align: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_vec[2:0] == 3'b011 && irq_src < IDX_W'(NUM_SRC)));

    a_r9_preempt_high_only: assert property (@(posedge clk) disable iff (rst)
        (irq && svc_lo) |-> pri[irq_src]);

    a_r10_block_in_high: assert property (@(posedge clk) disable iff (rst)
        svc_hi |-> !irq);

    a_r11_nesting_order: assert property (@(posedge clk) disable iff (rst)
        $rose(svc_hi) |-> $stable(svc_lo));
endmodule

bind intc_top intc_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .irq    (irq),
    .irq_src(irq_src),
    .irq_vec(irq_vec),
    .en_glb (en_glb_q),
    .en_src (en_src_q),
    .pri    (pri_q),
    .svc_lo (svc_lo),
    .svc_hi (svc_hi)
);

// File: tb/sim_intc_top.sv
module sim_intc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ext_n = 2'b11;
    logic        tmr0_req = 1'b0, tmr1_req = 1'b0, ser_req = 1'b0;
    logic        mode_we = 1'b0, en_we = 1'b0, pri_we = 1'b0;
    logic [1:0]  mode_wdata = '0;
    logic [5:0]  en_wdata = '0;
    logic [4:0]  pri_wdata = '0;
    logic        ack = 1'b0, reti = 1'b0;
    logic        irq;
    logic [2:0]  irq_src;
    logic [15:0] irq_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    intc_top u0 (
        .clk(clk), .rst(rst), .ext_n(ext_n),
        .tmr0_req(tmr0_req), .tmr1_req(tmr1_req), .ser_req(ser_req),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .en_we(en_we), .en_wdata(en_wdata),
        .pri_we(pri_we), .pri_wdata(pri_wdata),
        .ack(ack), .reti(reti),
        .irq(irq), .irq_src(irq_src), .irq_vec(irq_vec)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic expect_none(input string req);
        checks++;
        if (irq !== 1'b0) begin
            failures++;
            $display("FAIL %s irq actual=%b expected=0 (src=%0d)", req, irq, irq_src);
        end
    endtask

    task automatic expect_src(input string req, input int src);
        logic [15:0] v;
        v = 16'h0003 + 16'(src * 8);
        checks++;
        if (irq !== 1'b1 || irq_src !== 3'(src) || irq_vec !== v) begin
            failures++;
            $display("FAIL %s actual irq=%b src=%0d vec=%h expected irq=1 src=%0d vec=%h",
                     req, irq, irq_src, irq_vec, src, v);
        end
    endtask

    task automatic do_reset();
        ext_n = 2'b11; tmr0_req = 0; tmr1_req = 0; ser_req = 0;
        ack = 0; reti = 0; mode_we = 0; en_we = 0; pri_we = 0;
        rst = 1;
        tick(2);
        rst = 0;
        tick(1);
    endtask

    task automatic wr_en(input logic [5:0] d);
        en_we = 1; en_wdata = d; tick(1); en_we = 0;
    endtask
    task automatic wr_pri(input logic [4:0] d);
        pri_we = 1; pri_wdata = d; tick(1); pri_we = 0;
    endtask
    task automatic wr_mode(input logic [1:0] d);
        mode_we = 1; mode_wdata = d; tick(1); mode_we = 0;
    endtask
    task automatic pulse_ack();
        ack = 1; tick(1); ack = 0;
    endtask
    task automatic pulse_reti();
        reti = 1; tick(1); reti = 0;
    endtask

    task automatic t_reset();
        do_reset();
        tmr0_req = 1; tmr1_req = 1; ser_req = 1; ext_n = 2'b00;
        tick(3);
        expect_none("R1 reset state masks all");
        tmr0_req = 0; tmr1_req = 0; ser_req = 0; ext_n = 2'b11;
        wr_en(6'b10_0001);
        ext_n[0] = 1'b0;
        tick(1);
        expect_none("R4 level ext0 too early");
        tick(1);
        expect_src("R1 R4 default level mode ext0", 0);
    endtask

    task automatic t_global();
        do_reset();
        wr_en(6'b01_1111);
        tmr0_req = 1; ser_req = 1;
        tick(2);
        expect_none("R2 global enable clear");
        wr_en(6'b11_1111);
        expect_src("R2 global enable set", 1);
    endtask

    task automatic t_src_en();
        do_reset();
        wr_en(6'b10_1000);
        tmr0_req = 1;
        tick(1);
        expect_none("R3 disabled timer0 ignored");
        tmr1_req = 1;
        #1 expect_src("R3 R8 enabled timer1 wins", 3);
    endtask

    task automatic t_order();
        do_reset();
        wr_en(6'b11_1111);
        tmr0_req = 1; tmr1_req = 1; ser_req = 1;
        #1 expect_src("R6 timer0 first", 1);
        tmr0_req = 0;
        #1 expect_src("R6 timer1 next", 3);
        tmr1_req = 0;
        #1 expect_src("R6 R8 serial last", 4);
        ext_n[1] = 1'b0;
        tick(2);
        expect_src("R6 ext1 before serial", 2);
    endtask

    task automatic t_priority();
        do_reset();
        wr_en(6'b11_1111);
        wr_pri(5'b10000);
        tmr0_req = 1; ser_req = 1;
        #1 expect_src("R7 high serial beats low timer0", 4);
        ext_n[0] = 1'b0;
        tick(2);
        expect_src("R7 high serial beats low ext0", 4);
    endtask

    task automatic t_level();
        do_reset();
        wr_en(6'b10_0100);
        ext_n[1] = 1'b0;
        tick(2);
        expect_src("R4 level ext1 asserted", 2);
        pulse_ack();
        tick(2);
        expect_none("R10 same level waits in service");
        pulse_reti();
        expect_src("R4 R11 re-request after return", 2);
        pulse_ack();
        ext_n[1] = 1'b1;
        pulse_reti();
        tick(2);
        expect_none("R4 released pin no request");
    endtask

    task automatic t_edge();
        do_reset();
        wr_en(6'b10_0001);
        wr_mode(2'b01);
        ext_n[0] = 1'b0;
        tick(2);
        expect_none("R5 edge not yet latched");
        tick(1);
        expect_src("R5 edge latched", 0);
        ext_n[0] = 1'b1;
        tick(4);
        expect_src("R5 edge held after release", 0);
        pulse_ack();
        expect_none("R5 ack clears pending");
        pulse_reti();
        tick(2);
        expect_none("R5 no request after return");
    endtask

    task automatic t_preempt();
        do_reset();
        wr_en(6'b11_1111);
        wr_pri(5'b01000);
        tmr0_req = 1;
        #1 expect_src("R7 low timer0 alone", 1);
        pulse_ack();
        tmr0_req = 0;
        tmr1_req = 1;
        #1 expect_src("R9 high preempts low service", 3);
        pulse_ack();
        tmr1_req = 0;
        ser_req = 1;
        tick(1);
        expect_none("R10 low waits during nested service");
        pulse_reti();
        expect_none("R11 return ends high only");
        pulse_reti();
        expect_src("R11 serial after both returns", 4);
    endtask

    initial begin
        t_reset();
        t_global();
        t_src_en();
        t_order();
        t_priority();
        t_level();
        t_edge();
        t_preempt();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule